// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This block is a purely combinational permutation network for an integer execution pipe. It takes an operand of XLEN bits (32 or 64) and a control value. It passes the operand through a chain of swap stages, and each stage is enabled by one bit of the control value. Stage i swaps every bit with its neighbour at distance 2^i, so stage 0 swaps adjacent bits, stage 1 swaps adjacent bit pairs, and so on. The stages are applied in order of increasing distance, up to the largest distance below the operating width.

Different control values give useful permutations:
- a control of zero leaves the operand unchanged;
- a control of width minus one reverses every bit;
- a control of width minus eight swaps the byte order.

A 32-bit word mode on the 64-bit configuration works on the low half only and sign-extends the outcome. When the control comes from an immediate field, values outside the operating width raise an illegal flag. Operand fetch, result write-back and the rest of instruction decode sit outside the block.

Top module: `grev_unit`

## Requirements
- R1: In the register form without word mode, bit b of the result equals bit b XOR 2^i of the value after stage i-1, for every stage i whose control bit i is set. Stages apply for i = 0 up to log2(XLEN)-1, in increasing order. The number of set bits is preserved.
- R2: A control value of 0 returns the operand unchanged, with illegal = 0.
- R3: A control value of XLEN-1 returns the operand with bit b moved to bit XLEN-1-b.
- R4: A control value of XLEN-8 returns the operand with its byte order reversed, and the bit order within each byte kept.
- R5: In the register form, control bits at or above bit log2(operating width) have no effect on the result, and illegal stays 0.
- R6: In the immediate form (`imm_sel` = 1), a control value at or above the operating width sets `illegal` = 1 and forces `result` to 0. The operating width is 32 in word mode and XLEN otherwise.
- R7: In the immediate form, a control value below the operating width gives `illegal` = 0 and the same result as the register form.
- R8: In word mode (`word_sel` = 1, XLEN = 64), the operand is zero-extended from bits 31:0 and only stages 0 to 4 apply. Result bits 63:32 all copy result bit 31.
- R9: In word mode with the register form, control bits 5 and above have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand | input | XLEN | Value to permute |
| ctrl | input | XLEN | Control value; bit i enables swap stage i |
| imm_sel | input | 1 | 1 = control taken from an immediate field, so it is range checked |
| word_sel | input | 1 | 1 = 32-bit word mode (effective only when XLEN = 64) |
| result | output | XLEN | Permuted value |
| illegal | output | 1 | Immediate control out of range for the operating width |

## Verification
Two functions meet on a single input set: the immediate range check and word mode. A shift amount from 32 to 63 is legal at full width, but the same amount is illegal once word mode narrows the width to 32. The bench drives these immediates with and without `word_sel` on consecutive cycles and expects the flag and a zeroed result only in the word case. Word mode also meets the bit reversal. A control of 31 on an operand with bit 0 set moves a one into bit 31, and the bench expects the sign extension to fill the upper half with ones. In each case the expected value comes from a loop model that swaps bit b with bit b XOR 2^i.

// File: rtl/gbr_pkg.sv
package gbr_pkg;

  localparam int MAX_W = 64;

  // Mask selecting the lower partner of each pair swapped by stage idx:
  // bit b is kept low-side when bit idx of its index is 0.
  function automatic logic [MAX_W-1:0] lane_mask(input int idx);
    logic [MAX_W-1:0] m;
    for (int b = 0; b < MAX_W; b++) begin
      m[b] = ((b >> idx) & 1) == 0;
    end
    return m;
  endfunction

endpackage

// File: rtl/gbr_swap_stage.sv
module gbr_swap_stage
  import gbr_pkg::*;
#(
  parameter int W   = 64,
  parameter int IDX = 0
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);

  localparam int            SHIFT = 1 << IDX;
  localparam logic [W-1:0]  MASK  = W'(lane_mask(IDX));

  logic [W-1:0] swapped;

  always_comb begin
    swapped = ((din & MASK) << SHIFT) | ((din & ~MASK) >> SHIFT);
    dout    = en ? swapped : din;
  end

  // R1: a swap stage is a permutation, so the ones count never changes
  always_comb begin
    a_r1_stage_popcount: assert ($countones(dout) == $countones(din))
      else $error("stage %0d altered the ones count", IDX);
  end

endmodule

// File: rtl/gbr_ctrl_decode.sv
module gbr_ctrl_decode #(
  parameter int XLEN = 64,
  parameter int STG  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] ctrl,
  input  logic            imm_sel,
  input  logic            word_act,
  output logic [STG-1:0]  stage_en,
  output logic            illegal
);

  localparam int WORD_STG = 5;

  logic [XLEN-1:0] op_width;
  int              act_stg;

  always_comb begin
    op_width = word_act ? XLEN'(32) : XLEN'(XLEN);
    act_stg  = word_act ? WORD_STG : STG;
    illegal  = imm_sel && (ctrl >= op_width);
    for (int i = 0; i < STG; i++) begin
      stage_en[i] = ctrl[i] && (i < act_stg) && !illegal;
    end
  end

  // R6: only an immediate control can be flagged out of range
  always_comb begin
    a_r6_illegal_needs_imm: assert (!illegal || imm_sel)
      else $error("illegal raised in register form");
  end

  // R9: word mode never enables a stage at distance 32 or more
  generate
    if (STG > WORD_STG) begin : g_word_chk
      always_comb begin
        a_r9_word_top_stage_off: assert (!word_act || (stage_en[STG-1:WORD_STG] == '0))
          else $error("word mode enabled a wide stage");
      end
    end
  endgenerate

endmodule

// File: rtl/grev_unit.sv
module grev_unit
  import gbr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] operand,
  input  logic [XLEN-1:0] ctrl,
  input  logic            imm_sel,
  input  logic            word_sel,
  output logic [XLEN-1:0] result,
  output logic            illegal
);

  localparam int STG = $clog2(XLEN);

  logic            word_act;
  logic [XLEN-1:0] net_in;
  logic [XLEN-1:0] net_out;
  logic [XLEN-1:0] shaped;
  logic [STG-1:0]  stage_en;
  logic [XLEN-1:0] chain [STG+1];

  generate
    if (XLEN > 32) begin : g_wide
      assign word_act = word_sel;
      assign net_in   = word_sel ? {{(XLEN-32){1'b0}}, operand[31:0]} : operand;
      assign shaped   = word_act ? {{(XLEN-32){net_out[31]}}, net_out[31:0]} : net_out;
    end else begin : g_narrow
      logic unused_word;
      assign unused_word = word_sel;
      assign word_act    = 1'b0;
      assign net_in      = operand;
      assign shaped      = net_out;
    end
  endgenerate

  gbr_ctrl_decode #(
    .XLEN (XLEN),
    .STG  (STG)
  ) u_dec (
    .ctrl     (ctrl),
    .imm_sel  (imm_sel),
    .word_act (word_act),
    .stage_en (stage_en),
    .illegal  (illegal)
  );

  assign chain[0] = net_in;

  generate
    for (genvar i = 0; i < STG; i++) begin : g_stage
      gbr_swap_stage #(
        .W   (XLEN),
        .IDX (i)
      ) u_stage (
        .din  (chain[i]),
        .en   (stage_en[i]),
        .dout (chain[i+1])
      );
    end
  endgenerate

  assign net_out = chain[STG];
  assign result  = illegal ? '0 : shaped;

  // R2: zero control outside word mode is the identity
  always_comb begin
    a_r2_zero_ctrl_identity: assert (!(ctrl == '0 && !word_act) || (result == operand))
      else $error("zero control changed the operand");
  end

  // R6: a flagged immediate leaves nothing on the result
  always_comb begin
    a_r6_illegal_zero: assert (!illegal || (result == '0))
      else $error("illegal control produced a nonzero result");
  end

  // R8: word results are sign-extended copies of bit 31
  generate
    if (XLEN > 32) begin : g_sext_chk
      always_comb begin
        a_r8_word_sext: assert (!word_act || (result[XLEN-1:32] == {(XLEN-32){result[31]}}))
          else $error("word result not sign-extended");
      end
    end
  endgenerate

endmodule

// File: tb/grev_unit_test.sv
module grev_unit_test;

  localparam int XLEN = 64;

  typedef struct {
    logic [XLEN-1:0] res;
    logic            ill;
    string           tag;
  } exp_t;

  logic            clk;
  logic            rst_n;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] ctrl;
  logic            imm_sel;
  logic            word_sel;
  logic [XLEN-1:0] result;
  logic            illegal;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  grev_unit #(.XLEN(XLEN)) uut (
    .operand  (operand),
    .ctrl     (ctrl),
    .imm_sel  (imm_sel),
    .word_sel (word_sel),
    .result   (result),
    .illegal  (illegal)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  // Reference: each enabled stage moves bit b from position b ^ 2^i
  function automatic logic [XLEN-1:0] model(logic [XLEN-1:0] op, logic [XLEN-1:0] c,
                                            logic imm, logic wd);
    int w = wd ? 32 : XLEN;
    logic [XLEN-1:0] x, y;
    if (imm && c >= XLEN'(w)) return '0;
    x = wd ? {32'b0, op[31:0]} : op;
    for (int sh = 1; sh < w; sh = sh * 2) begin
      if ((c & XLEN'(sh)) != 0) begin
        for (int b = 0; b < XLEN; b++) y[b] = x[b ^ sh];
        x = y;
      end
    end
    if (wd) x = {{32{x[31]}}, x[31:0]};
    return x;
  endfunction

  task automatic drive(logic [XLEN-1:0] op, logic [XLEN-1:0] c, logic imm, logic wd,
                       logic [XLEN-1:0] exp_res, logic exp_ill, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    operand  = op;
    ctrl     = c;
    imm_sel  = imm;
    word_sel = wd;
    e.res = exp_res;
    e.ill = exp_ill;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drive_m(logic [XLEN-1:0] op, logic [XLEN-1:0] c, logic imm, logic wd,
                         string tag);
    logic ill;
    ill = imm && (c >= (wd ? XLEN'(32) : XLEN'(XLEN)));
    drive(op, c, imm, wd, model(op, c, imm, wd), ill, tag);
  endtask

  // Monitor: compare at the falling edge, away from driver activity
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        n_checks++;
        if (result !== e.res || illegal !== e.ill) begin
          n_fail++;
          $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                   e.tag, result, illegal, e.res, e.ill);
        end
      end
    end
  end

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] op, rev, c;
    rst_n = 0; operand = '0; ctrl = '0; imm_sel = 0; word_sel = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // reset state: all-zero inputs give zero result, no flag (R2)
    drive('0, '0, 0, 0, '0, 0, "R2 reset state");

    // R2: identity
    for (int k = 0; k < 4; k++) begin
      op = {$urandom, $urandom};
      drive(op, '0, 0, 0, op, 0, "R2 zero control identity");
    end

    // R3: full reversal, expected built by index mirroring
    for (int k = 0; k < 3; k++) begin
      op = {$urandom, $urandom};
      for (int b = 0; b < XLEN; b++) rev[b] = op[XLEN-1-b];
      drive(op, XLEN'(XLEN-1), 0, 0, rev, 0, "R3 full bit reversal");
    end

    // R4: byte swap
    op = 64'h0123_4567_89ab_cdef;
    drive(op, XLEN'(XLEN-8), 0, 0, 64'hefcd_ab89_6745_2301, 0, "R4 byte swap");
    op = {$urandom, $urandom};
    drive(op, XLEN'(XLEN-8), 0, 0, {<<8{op}}, 0, "R4 byte swap random");

    // R1: random controls, register form
    for (int k = 0; k < 40; k++) begin
      op = {$urandom, $urandom};
      c  = XLEN'($urandom_range(0, 63));
      drive_m(op, c, 0, 0, "R1 stage cascade");
    end
    drive_m(64'h1, 64'h1, 0, 0, "R1 single stage 0");
    drive_m(64'h1, 64'h20, 0, 0, "R1 single stage 5");

    // R5: high control bits ignored in register form
    for (int k = 0; k < 6; k++) begin
      op = {$urandom, $urandom};
      c  = XLEN'($urandom_range(0, 63));
      drive(op, c | {$urandom, $urandom, 6'b0} >> 0 | 64'hffc0, 0, 0,
            model(op, c, 0, 0), 0, "R5 upper control bits ignored");
    end

    // R6: immediate out of range
    drive(64'hdead_beef_0000_ffff, 64'd64, 1, 0, '0, 1, "R6 imm equals width");
    drive(64'hdead_beef_0000_ffff, 64'd200, 1, 0, '0, 1, "R6 imm far above width");
    // R7: immediate in range matches register form
    op = {$urandom, $urandom};
    drive(op, 64'd63, 1, 0, model(op, 64'd63, 0, 0), 0, "R7 imm at top of range");
    drive_m(op, 64'd13, 1, 0, "R7 imm mid range");

    // word mode meets the range check: 40 legal at full width, illegal in word mode
    drive_m(op, 64'd40, 1, 0, "R7 imm 40 full width");
    drive(op, 64'd40, 1, 1, '0, 1, "R6 imm 40 word mode");
    drive(op, 64'd32, 1, 1, '0, 1, "R6 imm 32 word mode");
    drive_m(op, 64'd31, 1, 1, "R7 imm 31 word mode");

    // R8: word mode sign extension after reversal
    drive(64'hffff_ffff_0000_0001, 64'd31, 0, 1, 64'hffff_ffff_8000_0000, 0,
          "R8 word reversal sign-extends");
    drive(64'h0000_0000_8000_0000, 64'd31, 0, 1, 64'h0000_0000_0000_0001, 0,
          "R8 word upper input discarded");
    for (int k = 0; k < 8; k++) begin
      op = {$urandom, $urandom};
      c  = XLEN'($urandom_range(0, 31));
      drive_m(op, c, 0, 1, "R8 word random");
    end

    // R9: word mode register form ignores bit 5 and up
    op = {$urandom, $urandom};
    drive(op, 64'h0000_0000_0000_003f, 0, 1, model(op, 64'd31, 0, 1), 0,
          "R9 word bit5 ignored");
    drive(op, 64'hffff_0000_0000_0fe7, 0, 1, model(op, 64'd7, 0, 1), 0,
          "R9 word high bits ignored");

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule